// File: doc/BRIEF.md
# Register-Driven SPI Master with Transfer Hold

This block is a byte-oriented SPI master that software drives through a small register port. A control register selects the operating mode: enable, master role, manual select, clock polarity and phase, and a hold bit that stops new transfers. The block shifts 8-bit elements out on `mosi`, most significant bit first, and takes 8-bit elements in from `miso`. It does this while the transmit queue holds data, the hold bit is clear, and both enable and master are set. A second register drives the active-low select lines directly, so one select stays low across any number of elements. The hold bit lets software pause between elements and refill the queue without releasing the select.

Two 16-entry byte queues sit between the register port and the shift engine. Software pushes into the transmit queue by writing the transmit data address. Software pops from the receive queue by reading the receive data address. The register port has no back-pressure. A write to a full transmit queue is dropped and flagged. A received element that finds the receive queue full is also dropped and flagged. The serial clock comes from a fixed half-period divider. It rests at the polarity level whenever no element is in flight, and it may rest there for any length of time between elements.

Three sticky event bits are collected in an event register: transfer done, receive overrun and transmit overflow. Writing 1 to a bit clears it. A single interrupt line reports any event whose enable bit is set, provided the global interrupt enable is set.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, `ss_n` is all ones, `irq` is 0, the control register reads 0x20 (only the hold bit set), the status register reads 0x05, and the event register reads 0x00.
- R2: Register addresses are: 0 control, 1 select, 2 transmit data (write), 3 receive data (read pops), 4 status, 5 events, 6 event enables, 7 global interrupt enable (bit 0). The control bits are: 0 enable, 1 master, 2 clock polarity, 3 clock phase, 4 manual select, 5 hold. When the manual select bit is set, `ss_n` equals the select register one cycle after it is written. When the manual select bit is clear, `ss_n` is all ones.
- R3: Whenever no element is in flight, `sclk` rests at the clock polarity bit. It follows a change of that bit within one cycle.
- R4: No element starts while the hold bit is set, or while enable or master is clear. Queued transmit data stays in the queue and `sclk` stays idle. Clearing the hold bit starts shifting the queued data.
- R5: Setting the hold bit while an element is in flight lets that element finish. No further element starts.
- R6: Each element is 8 bits, MSB first. In mode 3 (polarity 1, phase 1) and mode 0 (polarity 0, phase 0), data is sampled on the rising `sclk` edge. `mosi` changes half an `sclk` period before each sampling edge. The slave receives the transmit byte, and the bits on `miso` land as one byte in the receive queue.
- R7: The transmit queue holds 16 bytes. A write to the full queue is dropped and sets event bit 2 (transmit overflow).
- R8: An element that completes while the receive queue is full is dropped and sets event bit 1 (receive overrun). The earlier queued bytes are unchanged.
- R9: Event bit 0 (done) is set when an element completes and the transmit queue is empty.
- R10: Writing the event register clears exactly the bits written as 1. A bit that is set and cleared in the same cycle stays set.
- R11: `irq` is high exactly when global enable bit 0 is set and some event bit is set with its enable bit (same position at address 6) set.
- R12: Status bits are: 0 transmit empty, 1 transmit full, 2 receive empty, 3 receive full, 4 element in flight. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops the receive queue at address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NSS=4, FIFO_DEPTH=16 and HALF_DIV=2. With the full 16-entry depth, the queues reach full in a few hundred cycles, so both the dropped transmit write and the dropped received element are exercised at the real boundary. The two-cycle half period keeps each element at 32 cycles. That short element lets a hold written in mid-element land inside the element. It also lets a slave model on the `sclk` edges check every bit in modes 3 and 0.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_SSEL = 3'd1,
    A_TXD  = 3'd2,
    A_RXD  = 3'd3,
    A_STAT = 3'd4,
    A_EVT  = 3'd5,
    A_EEN  = 3'd6,
    A_GIE  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic hold;
    logic man;
    logic cpha;
    logic cpol;
    logic mst;
    logic en;
  } ctrl_t;

  localparam int EV_DONE = 0;
  localparam int EV_ROVR = 1;
  localparam int EV_TOVF = 2;
  localparam int EV_N    = 3;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic [3:0]    edg;
  logic [7:0]    sh_tx, sh_rx, rx_next;
  logic          samp, drv;

  // even edges lead, odd edges trail; phase picks which one samples
  assign samp    = (edg[0] == cpha);
  assign drv     = !samp && !(!cpha && edg == 4'd15);
  assign rx_next = samp ? {sh_rx[6:0], miso} : sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b1;
      cnt     <= '0;
      edg     <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy  <= 1'b1;
          cnt   <= '0;
          edg   <= '0;
          sh_rx <= '0;
          if (cpha) begin
            sh_tx <= tx_byte;
          end else begin
            mosi  <= tx_byte[7];
            sh_tx <= {tx_byte[6:0], 1'b0};
          end
        end
      end else if (cnt == LAST) begin
        cnt   <= '0;
        sclk  <= ~sclk;
        edg   <= edg + 4'd1;
        sh_rx <= rx_next;
        if (drv) begin
          mosi  <= sh_tx[7];
          sh_tx <= {sh_tx[6:0], 1'b0};
        end
        if (edg == 4'd15) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= rx_next;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NSS        = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int HALF_DIV   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic           reg_rd_en,
  input  logic [2:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] ss_n,
  output logic           irq
);
  ctrl_t           ctrl;
  logic [NSS-1:0]  ssel;
  logic [EV_N-1:0] evt, een, evt_set, evt_clr;
  logic            gie;

  logic wr_ctrl, wr_ssel, wr_txd, wr_evt, wr_een, wr_gie, rd_rxd;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0] tx_head, rx_head, sh_rx;
  logic sh_busy, sh_done, start;

  assign wr_ctrl = reg_wr_en && (reg_addr == A_CTRL);
  assign wr_ssel = reg_wr_en && (reg_addr == A_SSEL);
  assign wr_txd  = reg_wr_en && (reg_addr == A_TXD);
  assign wr_evt  = reg_wr_en && (reg_addr == A_EVT);
  assign wr_een  = reg_wr_en && (reg_addr == A_EEN);
  assign wr_gie  = reg_wr_en && (reg_addr == A_GIE);
  assign rd_rxd  = reg_rd_en && (reg_addr == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '{hold: 1'b1, default: 1'b0};
      ssel <= '1;
      een  <= '0;
      gie  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[5:0]);
      if (wr_ssel) ssel <= reg_wdata[NSS-1:0];
      if (wr_een)  een  <= reg_wdata[EV_N-1:0];
      if (wr_gie)  gie  <= reg_wdata[0];
    end
  end

  assign start = ctrl.en && ctrl.mst && !ctrl.hold && !tx_empty && !sh_busy;

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_txd), .din(reg_wdata),
    .pop(start), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(sh_done), .din(sh_rx),
    .pop(rd_rxd), .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spim_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .cpol(ctrl.cpol), .cpha(ctrl.cpha),
    .start(start), .tx_byte(tx_head), .miso(miso), .busy(sh_busy),
    .sclk(sclk), .mosi(mosi), .done(sh_done), .rx_byte(sh_rx)
  );

  // events: set wins over a same-cycle write-one clear
  always_comb begin
    evt_set          = '0;
    evt_set[EV_DONE] = sh_done && tx_empty;
    evt_set[EV_ROVR] = sh_done && rx_full;
    evt_set[EV_TOVF] = wr_txd && tx_full;
    evt_clr          = wr_evt ? reg_wdata[EV_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= (evt & ~evt_clr) | evt_set;
  end

  assign irq  = gie && |(evt & een);
  assign ss_n = ctrl.man ? ssel : '1;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: reg_rdata[5:0]      = ctrl;
      A_SSEL: reg_rdata[NSS-1:0]  = ssel;
      A_TXD:  reg_rdata           = '0;
      A_RXD:  reg_rdata           = rx_head;
      A_STAT: reg_rdata[4:0]      = {sh_busy, rx_full, rx_empty, tx_full, tx_empty};
      A_EVT:  reg_rdata[EV_N-1:0] = evt;
      A_EEN:  reg_rdata[EV_N-1:0] = een;
      A_GIE:  reg_rdata[0]        = gie;
      default: reg_rdata          = '0;
    endcase
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       sclk,
  input logic       cpol,
  input logic       hold,
  input logic       en,
  input logic       mst,
  input logic       tx_wr,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       done,
  input logic       rx_full,
  input logic [2:0] evt
);
  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

  // R4
  no_start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!hold && en && mst));

  // R7
  tx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> evt[2]);

  // R8
  rx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full) |=> evt[1]);

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tx_empty) |=> evt[0]);
endmodule

bind spim_ctrl spim_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(sh_busy), .sclk(sclk),
  .cpol(ctrl.cpol), .hold(ctrl.hold), .en(ctrl.en), .mst(ctrl.mst),
  .tx_wr(wr_txd), .tx_full(tx_full), .tx_empty(tx_empty),
  .done(sh_done), .rx_full(rx_full), .evt(evt)
);

// File: tb/spim_ctrl_tb_top.sv
module spim_ctrl_tb_top;
  localparam int NSS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sclk, mosi, irq;
  logic miso = 1'b1;
  logic [NSS-1:0] ss_n;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spim_ctrl #(.NSS(NSS), .FIFO_DEPTH(16), .HALF_DIV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq(irq)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'hA0 + 8'(i);
  endfunction

  // slave model: samples on rising sclk, drives on falling (modes 0 and 3)
  logic [7:0] s_in = '0;
  int s_bits = 0, s_idx = 0;
  logic [7:0] s_got [64];

  always @(posedge sclk) begin
    if (!ss_n[0]) begin
      s_in = {s_in[6:0], mosi};
      if (s_bits == 7) begin
        s_got[s_idx % 64] = s_in;
        s_idx = s_idx + 1;
        s_bits = 0;
      end else begin
        s_bits = s_bits + 1;
      end
    end
  end

  always @(negedge sclk or negedge ss_n[0]) begin
    logic [7:0] p;
    if (!ss_n[0]) begin
      p = pat(s_idx);
      miso = p[7 - s_bits];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    bit ok = 1'b0;
    for (int n = 0; n < 3000 && !ok; n++) begin
      rd(3'd4, s);
      if (!s[4] && s[0]) ok = 1'b1;
    end
    if (!ok) chk({tag, " timeout"}, 0, 1);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81, 8'h7E, 8'h3C, 8'hC3};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ss_n", ss_n, 4'hF);
    chk("R1 irq", irq, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 8'h20);
    rd(3'd4, d); chk("R1/R12 status", d, 8'h05);
    rd(3'd5, d); chk("R1 events", d, 8'h00);

    // R3 idle level after enabling mode 3 with hold set
    wr(3'd0, 8'h3F);
    repeat (2) @(negedge clk);
    chk("R3 sclk idle high", sclk, 1);
    // R2 select mirrors register
    wr(3'd1, 8'h0E);
    chk("R2 ss_n mirror", ss_n, 4'hE);

    // R4 master clear: nothing starts
    wr(3'd0, 8'h1D);
    wr(3'd2, 8'h11);
    repeat (60) @(negedge clk);
    rd(3'd4, d); chk("R4 no start without master", d[4:0], 5'b00100);
    chk("R4 slave untouched", s_idx, 0);
    // R4 hold set: nothing starts
    wr(3'd0, 8'h3F);
    repeat (60) @(negedge clk);
    rd(3'd4, d); chk("R4 no start while held", d[4:0], 5'b00100);
    chk("R4 sclk idle while held", sclk, 1);
    wr(3'd0, 8'h1F);
    wait_idle("R4");
    chk("R4 slave byte after release", s_got[0], 8'h11);
    rd(3'd3, d); chk("R6 rx byte", d, pat(0));

    // R6 vector table, mode 3
    foreach (VEC[i]) begin
      base = s_idx;
      wr(3'd2, VEC[i]);
      wait_idle("R6");
      chk("R6 slave got tx byte", s_got[base], VEC[i]);
      rd(3'd3, d); chk("R6 rx from miso", d, pat(base));
      chk("R3 sclk idle after element", sclk, 1);
    end

    // R9 / R11 / R10
    rd(3'd5, d); chk("R9 done flag", d[0], 1);
    chk("R11 irq masked by enable", irq, 0);
    wr(3'd6, 8'h01);
    chk("R11 irq masked by global", irq, 0);
    wr(3'd7, 8'h01);
    chk("R11 irq asserted", irq, 1);
    wr(3'd5, 8'h01);
    rd(3'd5, d); chk("R10 write-one clear", d, 8'h00);
    chk("R11 irq after clear", irq, 0);

    // R5 hold in mid-element
    base = s_idx;
    wr(3'd2, 8'h21); wr(3'd2, 8'h22); wr(3'd2, 8'h23);
    for (int n = 0; n < 100; n++) begin
      rd(3'd4, d);
      if (d[4]) break;
    end
    wr(3'd0, 8'h3F);
    repeat (200) @(negedge clk);
    chk("R5 element finished, none after", s_idx, base + 1);
    rd(3'd4, d); chk("R5 idle with data queued", {d[4], d[0]}, 2'b00);
    chk("R3 sclk idle during hold", sclk, 1);
    wr(3'd0, 8'h1F);
    wait_idle("R5");
    chk("R5 remaining sent", s_idx, base + 3);
    chk("R5 last byte", s_got[base + 2], 8'h23);
    for (int k = 0; k < 3; k++) begin
      rd(3'd3, d); chk("R5 rx order", d, pat(base + k));
    end

    // R7 transmit overflow
    wr(3'd0, 8'h3F);
    for (int k = 0; k < 17; k++) wr(3'd2, 8'h40 + 8'(k));
    rd(3'd4, d); chk("R12 status tx full", d, 8'h06);
    rd(3'd5, d); chk("R7 overflow flag", d[2], 1);
    wr(3'd5, 8'h00);
    rd(3'd5, d); chk("R10 zero write keeps bit", d[2], 1);

    // R8 receive overrun
    base = s_idx;
    wr(3'd0, 8'h1F);
    wait_idle("R7");
    chk("R7 sixteen sent", s_idx, base + 16);
    chk("R7 17th write dropped", s_got[base + 15], 8'h4F);
    rd(3'd4, d); chk("R12 status rx full", d, 8'h09);
    wr(3'd2, 8'h99);
    wait_idle("R8");
    chk("R8 element still shifted", s_got[base + 16], 8'h99);
    rd(3'd5, d); chk("R8 overrun flag", d[1], 1);
    for (int k = 0; k < 16; k++) begin
      rd(3'd3, d);
      if (k == 0 || k == 15) chk("R8 queued bytes intact", d, pat(base + k));
    end
    rd(3'd4, d); chk("R12 rx empty again", d[3:2], 2'b01);

    // R6 mode 0
    wr(3'd1, 8'h0F);
    wr(3'd0, 8'h33);
    repeat (2) @(negedge clk);
    chk("R3 sclk idle low", sclk, 0);
    wr(3'd1, 8'h0E);
    base = s_idx;
    wr(3'd2, 8'h96);
    wr(3'd0, 8'h13);
    wait_idle("R6 mode0");
    chk("R6 mode0 slave got", s_got[base], 8'h96);
    rd(3'd3, d); chk("R6 mode0 rx", d, pat(base));

    // R2 manual select off
    wr(3'd0, 8'h03);
    chk("R2 ss_n released", ss_n, 4'hF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule